// File: doc/BRIEF.md
# Big-Endian Byte and Word Data Memory Port

This block connects the execute stage of a simple processor to a data memory that is 32 bits wide and addressed by byte. For each request it adds the sign-extended 16-bit displacement to the base register value, rounds the result down to a word address, and drives byte-write enables and store data to the memory. It also reshapes the word that the memory returns into the value that the load instruction writes back.

Byte lanes follow big-endian numbering: the byte whose address ends in 0 occupies the most significant eight bits of the word. Word accesses must be aligned to four bytes. A word access with either low address bit set is flagged and never reaches the memory. Byte accesses are legal at any address. A byte store writes one lane, and a byte load returns a sign-extended value.

The memory is assumed to have one synchronous read port with a single-cycle latency. Every output is registered. The address and write strobes appear one cycle after the request, and a load result appears three cycles after it.

Top module: `be_mem_port`

## Requirements
- R1: During and right after synchronous reset, `mem_be`, `mem_rd`, `misalign` and `load_valid` are all 0.
- R2: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32. One cycle after an accepted request (`req_valid`=1), `mem_addr` holds that address with bits [1:0] cleared.
- R3: An aligned word store (`req_op`=2'b01) drives `mem_be`=4'b1111 and `mem_wdata`=`req_wdata` one cycle after the request, with `mem_rd`=0.
- R4: A byte store (`req_op`=2'b11) asserts exactly one enable. `mem_be[3-k]` is set for byte offset k, and `mem_be[i]` covers `mem_wdata[8i+7:8i]`. `mem_wdata` holds `req_wdata[7:0]` copied into all four lanes.
- R5: A byte load (`req_op`=2'b10) raises `mem_rd` one cycle after the request. Three cycles after the request it raises `load_valid` for one cycle. `load_data` then holds the byte at offset k, taken from bits [31-8k:24-8k], in bits [7:0], with bit 7 copied into bits [31:8].
- R6: An aligned word load (`req_op`=2'b00) raises `mem_rd` one cycle after the request. Three cycles after the request, `load_valid`=1 and `load_data` equals the whole addressed word.
- R7: A word access (`req_op` 2'b00 or 2'b01) whose effective address has bit 1 or bit 0 set raises `misalign` for one cycle, one cycle after the request. It keeps `mem_be`=0 and `mem_rd`=0, produces no `load_valid`, and leaves the memory contents unchanged.
- R8: Byte accesses never raise `misalign`, whatever their offset.
- R9: In a cycle after one with `req_valid`=0, `mem_be`=0, `mem_rd`=0 and `misalign`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 load word, 01 store word, 10 load byte, 11 store byte |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Source register value for stores |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-write enables, bit i covers bits [8i+7:8i] |
| mem_rd | output | 1 | Read strobe |
| mem_wdata | output | 32 | Store data laid out by lane |
| mem_rdata | input | 32 | Word read from memory, one cycle after `mem_rd` |
| misalign | output | 1 | Misaligned word access detected |
| load_valid | output | 1 | `load_data` is valid |
| load_data | output | 32 | Formatted load result |

## Verification
The assertions check several properties on every cycle. A misaligned access never writes or reads. An idle cycle is followed by quiet strobes. Write enables are either all four lanes or at most one. Every load result follows a read strobe by exactly two cycles, and every byte result carries a proper sign extension. Other behaviour shows up only in the bench scenarios, which compare against a shadow memory. These cover the correct big-endian lane choice, the effective-address arithmetic with negative displacements and wrap-around, and the fact that a rejected store leaves memory untouched.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;
  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_STW = 2'b01,
    OP_LDB = 2'b10,
    OP_STB = 2'b11
  } mem_op_e;

  function automatic logic op_is_store(input mem_op_e op);
    return op[0];
  endfunction

  function automatic logic op_is_byte(input mem_op_e op);
    return op[1];
  endfunction
endpackage

// File: rtl/be_mem_agu.sv
module be_mem_agu #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LANE_W-1:0] lane
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] eff;

  always_comb begin
    eff       = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    lane      = eff[LANE_W-1:0];
    word_addr = {eff[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  end
endmodule

// File: rtl/be_mem_store_steer.sv
module be_mem_store_steer #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LANE_W = 2
) (
  input  logic              is_store,
  input  logic              is_byte,
  input  logic              reject,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  // Big-endian: address offset k maps to physical lane LANES-1-k.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int OFS = LANES - 1 - i;
    always_comb begin
      if (!is_store || reject)
        be[i] = 1'b0;
      else if (is_byte)
        be[i] = (int'(lane) == OFS);
      else
        be[i] = 1'b1;
      wdata[8*i +: 8] = is_byte ? src[7:0] : src[8*i +: 8];
    end
  end
endmodule

// File: rtl/be_mem_load_format.sv
module be_mem_load_format #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_byte,
  input  logic [LANE_W-1:0] in_lane,
  input  logic [DATA_W-1:0] rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [7:0]        picked;
  logic [DATA_W-1:0] shaped;
  logic              byte_q;

  always_comb begin
    picked = rdata[DATA_W-1 -: 8];
    for (int k = 0; k < LANES; k++)
      if (int'(in_lane) == k) picked = rdata[DATA_W-1-8*k -: 8];
    shaped = in_byte ? {{(DATA_W-8){picked[7]}}, picked} : rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      byte_q    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      byte_q    <= in_byte;
      if (in_valid) out_data <= shaped;
    end
  end

  // R5
  byte_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && byte_q) |-> (out_data[DATA_W-1:8] == {(DATA_W-8){out_data[7]}}));
endmodule

// File: rtl/be_mem_port.sv
module be_mem_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic              mem_rd,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              misalign,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_data
);
  import be_mem_pkg::*;

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  mem_op_e           op;
  logic              st, by, bad;
  logic [ADDR_W-1:0] waddr;
  logic [LANE_W-1:0] lane;
  logic [LANES-1:0]  be_n;
  logic [DATA_W-1:0] wd_n;

  logic [LANE_W-1:0] s1_lane, s2_lane;
  logic              s1_byte, s2_byte, s2_valid;

  assign op  = mem_op_e'(req_op);
  assign st  = op_is_store(op);
  assign by  = op_is_byte(op);
  assign bad = !by && (lane != '0);

  be_mem_agu #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_agu (
    .base(req_base), .offset(req_offset), .word_addr(waddr), .lane(lane));

  be_mem_store_steer #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) u_steer (
    .is_store(st), .is_byte(by), .reject(bad), .lane(lane),
    .src(req_wdata), .be(be_n), .wdata(wd_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_rd    <= 1'b0;
      mem_wdata <= '0;
      misalign  <= 1'b0;
      s1_lane   <= '0;
      s1_byte   <= 1'b0;
      s2_lane   <= '0;
      s2_byte   <= 1'b0;
      s2_valid  <= 1'b0;
    end else begin
      mem_be   <= req_valid ? be_n : '0;
      mem_rd   <= req_valid && !st && !bad;
      misalign <= req_valid && bad;
      if (req_valid) begin
        mem_addr  <= waddr;
        mem_wdata <= wd_n;
        s1_lane   <= lane;
        s1_byte   <= by;
      end
      s2_valid <= mem_rd;
      s2_lane  <= s1_lane;
      s2_byte  <= s1_byte;
    end
  end

  be_mem_load_format #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) u_fmt (
    .clk(clk), .rst(rst), .in_valid(s2_valid), .in_byte(s2_byte), .in_lane(s2_lane),
    .rdata(mem_rdata), .out_valid(load_valid), .out_data(load_data));

  // R7
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (mem_be == '0 && !mem_rd));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (mem_be == '0 && !mem_rd && !misalign));

  // R4
  be_shape_chk: assert property (@(posedge clk) disable iff (rst)
    !(&mem_be) |-> $onehot0(mem_be));

  // R6
  load_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> $past(mem_rd, 2));

  // R3
  no_rd_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_be != '0) |-> !mem_rd);
endmodule

// File: tb/be_mem_port_bench.sv
`timescale 1ns/1ps
module be_mem_port_bench;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic        mem_rd;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        misalign;
  logic        load_valid;
  logic [31:0] load_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] mem [DEPTH];
  logic [31:0] sh  [DEPTH];

  always #2 clk = ~clk;

  be_mem_port u_be_mem_port (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .misalign(misalign), .load_valid(load_valid),
    .load_data(load_data));

  function automatic logic [31:0] seed_word(int i);
    return 32'h9E37_79B9 * (i + 1) ^ 32'h0080_8000;
  endfunction

  // behavioural memory: synchronous read, per-byte write
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= seed_word(i);
      mem_rdata <= '0;
    end else begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(logic [1:0] op, logic [31:0] base, logic [15:0] off, logic [31:0] d);
    logic [31:0] ea, wa, word, exp_ld;
    logic [1:0]  k;
    logic        isb, ist, bad;
    ea  = base + {{16{off[15]}}, off};
    wa  = {ea[31:2], 2'b00};
    k   = ea[1:0];
    isb = op[1];
    ist = op[0];
    bad = !isb && (k != 2'b00);
    @(negedge clk);
    req_op = op; req_base = base; req_offset = off; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 misalign flag", {31'd0, misalign}, {31'd0, bad});
    if (isb) chk("R8 byte never misaligned", {31'd0, misalign}, 32'd0);
    if (!bad) chk("R2 word address", mem_addr, wa);
    chk("R5/R6 read strobe", {31'd0, mem_rd}, {31'd0, !ist && !bad});
    if (bad || !ist) chk("R7 no write enables", {28'd0, mem_be}, 32'd0);
    else if (isb) begin
      chk("R4 byte lane enable", {28'd0, mem_be}, 32'(4'b1000 >> k));
      chk("R4 replicated data", mem_wdata, {4{d[7:0]}});
      sh[wa[7:2]][31-8*k -: 8] = d[7:0];
    end else begin
      chk("R3 word enables", {28'd0, mem_be}, 32'h0000_000F);
      chk("R3 word data", mem_wdata, d);
      sh[wa[7:2]] = d;
    end
    word = sh[wa[7:2]];
    @(negedge clk);
    chk("R9 quiet after idle", {27'd0, mem_be, mem_rd}, 32'd0);
    @(negedge clk);
    chk("R7 load valid", {31'd0, load_valid}, {31'd0, !ist && !bad});
    if (!ist && !bad) begin
      if (isb) begin
        exp_ld = {{24{word[31-8*k]}}, word[31-8*k -: 8]};
        chk("R5 byte load", load_data, exp_ld);
      end else
        chk("R6 word load", load_data, word);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < DEPTH; i++) sh[i] = seed_word(i);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, mem_be, mem_rd, misalign, load_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {28'd0, mem_be, mem_rd, misalign, load_valid}, 32'd0);
    chk("R9 idle", {31'd0, misalign}, 32'd0);

    // word store then byte loads at every big-endian offset
    access(2'b01, 32'h0000_0040, 16'h0000, 32'h80_7F_C3_01);
    for (int k = 0; k < 4; k++) access(2'b10, 32'h0000_0040, 16'(k), '0);
    // byte stores at every offset, then word load
    for (int k = 0; k < 4; k++) access(2'b11, 32'h0000_0050, 16'(k), 32'hFFFF_FF10 + 32'(k));
    access(2'b00, 32'h0000_0050, 16'h0000, '0);
    // misaligned word stores leave memory unchanged
    for (int k = 1; k < 4; k++) access(2'b01, 32'h0000_0060, 16'(k), 32'hDEAD_BEEF);
    access(2'b00, 32'h0000_0060, 16'h0000, '0);
    access(2'b00, 32'h0000_0061, 16'h0000, '0);
    // negative offset and wrap-around
    access(2'b00, 32'h0000_0088, 16'hFFF8, '0);
    access(2'b01, 32'h0000_0002, 16'hFFFE, 32'h1234_5678);
    access(2'b10, 32'hFFFF_FFFF, 16'h0001, '0);
    access(2'b00, 32'h0000_0000, 16'h0000, '0);

    for (int n = 0; n < 400; n++)
      access(2'($urandom), $urandom, 16'($urandom), $urandom);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule